// File: doc/BRIEF.md
# Addressed Three-Wire Control Port

This block is the slave end of a three-wire serial control link. A host drives an enable line, a serial clock and a data line. The block answers on one open-drain return line. The port fills two 24-bit control registers that the rest of the chip decodes, and it gives back a 23-bit status word. The status word holds two sampled pin levels, a lock indication and a 20-bit counter value.

Each exchange begins with an 8-bit address, clocked in while enable is low. The address is decoded when enable rises. During the enable-high period that follows, the block accepts write data or shifts out the status word. Write data takes effect only when enable falls, and only if the bit count was exactly right.

Between exchanges the return line acts as a configurable status output. A 3-bit select field in the second control register chooses what it shows. All serial lines are brought into the system clock domain through synchronisers and sampled on detected edges. The open-drain pin itself is represented by a pull-low request.

Top module: `ctl3w_port`

## Requirements
- R1: The address is 8 bits, sent least significant bit first, one bit per rising serial clock while enable is low. It is decoded on the rising edge of enable: 0x82 selects a write to control register 1, 0x92 a write to control register 2, and 0xA2 a status read.
- R2: After reset both control registers read zero, the return line is released, and the lock indication in the first read is 1.
- R3: In a write mode, data bits are taken on rising serial clock edges, first bit into register bit 0. The addressed register takes the 24 bits on the falling edge of enable, and not before.
- R4: A write period that delivers any number of data bits other than 24 leaves both control registers unchanged.
- R5: While a write period is open, the return line is released whatever the select field holds.
- R6: A read shifts out, most significant first, the IO2 pin level, the IO1 pin level, the lock bit (1 = locked or detection stopped) and counter bits C19 down to C0. A bit reads 1 when the line is released and 0 when it is pulled low. The first bit is present once enable is high, each falling serial clock moves to the next bit, and bits beyond the 23rd read 0.
- R7: Pin levels, lock bit and counter value are captured when the read address is decoded; later changes do not appear in that read.
- R8: Outside exchanges, the select field is control register 2 bits [2:0]. Code 001 pulls the line low while the unlock flag is set. Code 010 pulls it low while the count-complete input is high. Code 101 pulls it low while IO1 is low, and code 110 while IO2 is low. Every other code releases the line.
- R9: The unlock flag is set by an unlock event and stays set until the next valid address decode (read or write). A read after an event returns lock bit 0, and the following read returns 1 if no further event occurred.
- R10: An unrecognised address makes the block ignore the rest of that enable period. Both control registers and the unlock flag stay unchanged, and the return line stays released during that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Serial enable from host |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| io1_pin_i | input | 1 | Level of dual-use pin 1 |
| io2_pin_i | input | 1 | Level of dual-use pin 2 |
| unlock_evt_i | input | 1 | One-cycle pulse from the lock detector on an unlock |
| count_done_i | input | 1 | High when the frequency count has completed |
| count_val_i | input | 20 | Current frequency counter value |
| ctrl1_o | output | 24 | Control register 1 |
| ctrl2_o | output | 24 | Control register 2 (bits [2:0] select the idle status source) |
| sdo_pull_o | output | 1 | 1 = pull the open-drain return line low |

## Verification
A decode or bit-count fault shows up as a control register that changes after a malformed or foreign frame. It can also show up as one that fails to change after a good frame, and this is visible one clock after enable falls. A fault in the read shifter or in capture timing corrupts the serial word in a particular bit position, so reads are compared bit by bit against a word built from the pin and counter levels at the moment of selection. A fault in the unlock flag appears only across two consecutive reads or through the idle status output, so those paths are checked in pairs, with a foreign frame between them.

// File: rtl/ctl3w_pkg.sv
// Shared types and constants of the three-wire control port.
package ctl3w_pkg;

    // Phase of the serial exchange as seen by the receiver.
    typedef enum logic [2:0] {
        M_IDLE = 3'd0,
        M_WR1  = 3'd1,
        M_WR2  = 3'd2,
        M_READ = 3'd3,
        M_SKIP = 3'd4
    } mode_e;

    // Idle status-output select codes.
    localparam logic [2:0] SEL_UNLOCK = 3'b001;
    localparam logic [2:0] SEL_DONE   = 3'b010;
    localparam logic [2:0] SEL_IO1    = 3'b101;
    localparam logic [2:0] SEL_IO2    = 3'b110;

endpackage

// File: rtl/ctl3w_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit lines.
// Assumes each input is held for many system clocks, so no pulse is lost.
module ctl3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture flop of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d_i;
            end
        end else begin : g_rest
            // Further metastability-settling flops.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ctl3w_rx.sv
// Serial receiver: collects the address while enable is low, decodes it on
// enable rise, gathers write data and commits it to the addressed control
// register on enable fall when exactly DATA_W bits arrived.
// Assumes edge pulses are single-cycle and come from synchronised lines.
module ctl3w_rx
    import ctl3w_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 24,
    parameter logic [ADDR_W-1:0] ADDR_WR1 = 8'h82,
    parameter logic [ADDR_W-1:0] ADDR_WR2 = 8'h92,
    parameter logic [ADDR_W-1:0] ADDR_RD  = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lvl_i,
    input  logic              ce_rise_i,
    input  logic              ce_fall_i,
    input  logic              sclk_rise_i,
    input  logic              sdi_i,
    output mode_e             mode_o,
    output logic              rd_start_o,
    output logic              xfer_start_o,
    output logic              ld1_o,
    output logic              ld2_o,
    output logic [DATA_W-1:0] ctrl1_o,
    output logic [DATA_W-1:0] ctrl2_o
);

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DATA_W + 1);

    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;
    logic [CNT_W-1:0]  bit_cnt;
    mode_e             mode_q;
    logic              hit_wr1, hit_wr2, hit_rd, in_write;

    assign hit_wr1  = (addr_sh == ADDR_WR1);
    assign hit_wr2  = (addr_sh == ADDR_WR2);
    assign hit_rd   = (addr_sh == ADDR_RD);
    assign in_write = (mode_q == M_WR1) || (mode_q == M_WR2);

    // Address shift register, LSB first, active only while enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                      addr_sh <= '0;
        else if (ce_fall_i)              addr_sh <= '0;
        else if (!ce_lvl_i && sclk_rise_i) addr_sh <= {sdi_i, addr_sh[ADDR_W-1:1]};
    end

    // Exchange phase: decoded on enable rise, closed on enable fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
        end else if (ce_rise_i) begin
            if (hit_wr1)      mode_q <= M_WR1;
            else if (hit_wr2) mode_q <= M_WR2;
            else if (hit_rd)  mode_q <= M_READ;
            else              mode_q <= M_SKIP;
        end else if (ce_fall_i) begin
            mode_q <= M_IDLE;
        end
    end

    // Write data shift register with a saturating bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_sh <= '0;
            bit_cnt <= '0;
        end else if (ce_rise_i) begin
            data_sh <= '0;
            bit_cnt <= '0;
        end else if (in_write && sclk_rise_i) begin
            data_sh <= {sdi_i, data_sh[DATA_W-1:1]};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign ld1_o = ce_fall_i && (mode_q == M_WR1) && (bit_cnt == CNT_FULL);
    assign ld2_o = ce_fall_i && (mode_q == M_WR2) && (bit_cnt == CNT_FULL);

    // Control register bank, loaded only at a well-formed write close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl1_o <= '0;
            ctrl2_o <= '0;
        end else begin
            if (ld1_o) ctrl1_o <= data_sh;
            if (ld2_o) ctrl2_o <= data_sh;
        end
    end

    assign mode_o       = mode_q;
    assign rd_start_o   = ce_rise_i && hit_rd;
    assign xfer_start_o = ce_rise_i && (hit_wr1 || hit_wr2 || hit_rd);

endmodule

// File: rtl/ctl3w_tx.sv
// Return-line driver: holds the sticky unlock flag, captures and shifts the
// status word in read mode, and selects the idle status source otherwise.
// Assumes status inputs are already synchronous to clk.
module ctl3w_tx
    import ctl3w_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             rd_start_i,
    input  logic             xfer_start_i,
    input  logic             sclk_fall_i,
    input  logic [2:0]       sel_i,
    input  logic             io1_pin_i,
    input  logic             io2_pin_i,
    input  logic             unlock_evt_i,
    input  logic             count_done_i,
    input  logic [CNT_W-1:0] count_val_i,
    output logic             sticky_o,
    output logic             rd_bit_o,
    output logic             pull_o
);

    localparam int WORD_W = CNT_W + 3;

    logic [WORD_W-1:0] word_sh;
    logic              sticky_q;
    logic              idle_pull;

    // Sticky unlock flag: set by an event, cleared at a valid address decode.
    always_ff @(posedge clk) begin
        if (!rst_n)            sticky_q <= 1'b0;
        else if (xfer_start_i) sticky_q <= unlock_evt_i;
        else if (unlock_evt_i) sticky_q <= 1'b1;
    end

    // Status word capture at read selection, then shift on falling clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_sh <= '0;
        else if (rd_start_i)
            word_sh <= {io2_pin_i, io1_pin_i, ~sticky_q, count_val_i};
        else if (mode_i == M_READ && sclk_fall_i)
            word_sh <= {word_sh[WORD_W-2:0], 1'b0};
    end

    // Idle status multiplexer.
    always_comb begin
        case (sel_i)
            SEL_UNLOCK: idle_pull = sticky_q;
            SEL_DONE:   idle_pull = count_done_i;
            SEL_IO1:    idle_pull = ~io1_pin_i;
            SEL_IO2:    idle_pull = ~io2_pin_i;
            default:    idle_pull = 1'b0;
        endcase
    end

    // Registered pull-low request for the open-drain return line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_o <= 1'b0;
        end else begin
            case (mode_i)
                M_READ:  pull_o <= ~word_sh[WORD_W-1];
                M_IDLE:  pull_o <= idle_pull;
                default: pull_o <= 1'b0;
            endcase
        end
    end

    assign sticky_o = sticky_q;
    assign rd_bit_o = word_sh[WORD_W-1];

endmodule

// File: rtl/ctl3w_port.sv
// Top of the addressed three-wire control port. Synchronises the serial
// lines, derives edge pulses and joins the receiver and return-line driver.
// Assumes the host holds each serial level for several system clocks.
module ctl3w_port
    import ctl3w_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 24,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              io1_pin_i,
    input  logic              io2_pin_i,
    input  logic              unlock_evt_i,
    input  logic              count_done_i,
    input  logic [CNT_W-1:0]  count_val_i,
    output logic [DATA_W-1:0] ctrl1_o,
    output logic [DATA_W-1:0] ctrl2_o,
    output logic              sdo_pull_o
);

    logic [2:0] sync_q;
    logic       ce_q, sclk_q, sdi_q, ce_d, sclk_d;
    logic       ce_rise, ce_fall, sclk_rise, sclk_fall;
    mode_e      mode_w;
    logic       rd_start_w, xfer_start_w, ld1_w, ld2_w, sticky_w, rd_bit_w;

    ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sdi_i, sclk_i, ce_i}),
        .q_o  (sync_q)
    );

    assign ce_q   = sync_q[0];
    assign sclk_q = sync_q[1];
    assign sdi_q  = sync_q[2];

    // Previous-level flops for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            ce_d   <= ce_q;
            sclk_d <= sclk_q;
        end
    end

    assign ce_rise   = ce_q & ~ce_d;
    assign ce_fall   = ~ce_q & ce_d;
    assign sclk_rise = sclk_q & ~sclk_d;
    assign sclk_fall = ~sclk_q & sclk_d;

    ctl3w_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_lvl_i    (ce_q),
        .ce_rise_i   (ce_rise),
        .ce_fall_i   (ce_fall),
        .sclk_rise_i (sclk_rise),
        .sdi_i       (sdi_q),
        .mode_o      (mode_w),
        .rd_start_o  (rd_start_w),
        .xfer_start_o(xfer_start_w),
        .ld1_o       (ld1_w),
        .ld2_o       (ld2_w),
        .ctrl1_o     (ctrl1_o),
        .ctrl2_o     (ctrl2_o)
    );

    ctl3w_tx #(.CNT_W(CNT_W)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_w),
        .rd_start_i  (rd_start_w),
        .xfer_start_i(xfer_start_w),
        .sclk_fall_i (sclk_fall),
        .sel_i       (ctrl2_o[2:0]),
        .io1_pin_i   (io1_pin_i),
        .io2_pin_i   (io2_pin_i),
        .unlock_evt_i(unlock_evt_i),
        .count_done_i(count_done_i),
        .count_val_i (count_val_i),
        .sticky_o    (sticky_w),
        .rd_bit_o    (rd_bit_w),
        .pull_o      (sdo_pull_o)
    );

endmodule

// File: rtl/ctl3w_port_chk.sv
// Property checker for ctl3w_port, attached by bind below.
// Assumes it observes the internal phase, decode and flag signals of the top.
module ctl3w_port_chk
    import ctl3w_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input mode_e             mode_w,
    input logic              ce_fall,
    input logic              ld1_w,
    input logic              ld2_w,
    input logic              rd_start_w,
    input logic              xfer_start_w,
    input logic              sticky_w,
    input logic              rd_bit_w,
    input logic              io2_pin_i,
    input logic              unlock_evt_i,
    input logic [DATA_W-1:0] ctrl1_o,
    input logic [DATA_W-1:0] ctrl2_o,
    input logic              sdo_pull_o
);

    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> ($stable(ctrl1_o) && $stable(ctrl2_o)));

    // R5
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == M_WR1 || mode_w == M_WR2) |=> !sdo_pull_o);

    // R10
    skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == M_SKIP) |=> (!sdo_pull_o && $stable(ctrl1_o) && $stable(ctrl2_o)));

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_evt_i && !xfer_start_w) |=> sticky_w);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_w && !xfer_start_w) |=> sticky_w);

    // R7
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_w |=> (rd_bit_w == $past(io2_pin_i)));

    // R3
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld1_w, ld2_w}));

endmodule

bind ctl3w_port ctl3w_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_w      (mode_w),
    .ce_fall     (ce_fall),
    .ld1_w       (ld1_w),
    .ld2_w       (ld2_w),
    .rd_start_w  (rd_start_w),
    .xfer_start_w(xfer_start_w),
    .sticky_w    (sticky_w),
    .rd_bit_w    (rd_bit_w),
    .io2_pin_i   (io2_pin_i),
    .unlock_evt_i(unlock_evt_i),
    .ctrl1_o     (ctrl1_o),
    .ctrl2_o     (ctrl2_o),
    .sdo_pull_o  (sdo_pull_o)
);

// File: tb/ctl3w_port_tb_top.sv
// Directed bench for ctl3w_port: one task per scenario, each self-checking.
module ctl3w_port_tb_top;

    localparam int HB = 8;
    localparam logic [7:0] A_WR1 = 8'h82;
    localparam logic [7:0] A_WR2 = 8'h92;
    localparam logic [7:0] A_RD  = 8'hA2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic        io1 = 1'b1, io2 = 1'b1, uevt = 1'b0, cdone = 1'b0;
    logic [19:0] cval = '0;
    logic [23:0] c1, c2;
    logic        pull;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ctl3w_port dut_i (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
        .io1_pin_i(io1), .io2_pin_i(io2), .unlock_evt_i(uevt),
        .count_done_i(cdone), .count_val_i(cval),
        .ctrl1_o(c1), .ctrl2_o(c2), .sdo_pull_o(pull)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        sdi = b;
        wait_n(HB);
        sclk = 1'b1;
        wait_n(HB);
        sclk = 1'b0;
        wait_n(HB);
    endtask

    task automatic open_frame(input logic [7:0] a);
        ce = 1'b0;
        wait_n(HB);
        for (int i = 0; i < 8; i++) clk_bit(a[i]);
        ce = 1'b1;
        wait_n(2 * HB);
    endtask

    task automatic close_frame();
        ce = 1'b0;
        wait_n(2 * HB);
    endtask

    task automatic write_frame(input logic [7:0] a, input logic [31:0] d, input int n);
        open_frame(a);
        for (int i = 0; i < n; i++) clk_bit(i < 32 ? d[i] : 1'b0);
        close_frame();
    endtask

    task automatic read_frame(input int n, input bit chg, output logic [31:0] got);
        got = '0;
        open_frame(A_RD);
        if (chg) begin
            io1 = ~io1; io2 = ~io2; cval = ~cval;
        end
        for (int i = 0; i < n; i++) begin
            got[n-1-i] = ~pull;
            sclk = 1'b1;
            wait_n(HB);
            sclk = 1'b0;
            wait_n(2 * HB);
        end
        close_frame();
        if (chg) begin
            io1 = ~io1; io2 = ~io2; cval = ~cval;
        end
    endtask

    task automatic pulse_unlock();
        uevt = 1'b1;
        wait_n(1);
        uevt = 1'b0;
        wait_n(2);
    endtask

    function automatic logic [31:0] word(input logic lk);
        return {9'd0, io2, io1, lk, cval};
    endfunction

    task automatic t_reset();
        logic [31:0] g;
        check("R2 ctrl1 after reset", c1, 0);
        check("R2 ctrl2 after reset", c2, 0);
        check("R2 line released after reset", pull, 0);
        read_frame(23, 1'b0, g);
        check("R2 first read lock bit set", g, word(1'b1));
    endtask

    task automatic t_writes();
        write_frame(A_WR1, 32'h5A3C96, 24);
        check("R1 R3 ctrl1 write", c1, 32'h5A3C96);
        check("R1 ctrl2 untouched by wr1", c2, 0);
        write_frame(A_WR2, 32'hC3F0A8, 24);
        check("R1 R3 ctrl2 write", c2, 32'hC3F0A8);
        check("R3 ctrl1 kept", c1, 32'h5A3C96);
        write_frame(A_WR1, 32'h000001, 24);
        check("R3 ctrl1 bit0 first", c1, 32'h000001);
        write_frame(A_WR1, 32'hFFFFFF, 24);
        check("R3 ctrl1 all ones", c1, 32'hFFFFFF);
    endtask

    task automatic t_bad_count();
        write_frame(A_WR1, 32'h123456, 23);
        check("R4 23 bits ignored", c1, 32'hFFFFFF);
        write_frame(A_WR1, 32'h123456, 25);
        check("R4 25 bits ignored", c1, 32'hFFFFFF);
        write_frame(A_WR2, 32'h0, 0);
        check("R4 zero bits ignored", c2, 32'hC3F0A8);
    endtask

    task automatic t_bad_addr();
        logic [31:0] g;
        pulse_unlock();
        write_frame(8'h83, 32'h0F0F0F, 24);
        check("R10 ctrl1 unchanged", c1, 32'hFFFFFF);
        write_frame(8'h28, 32'h0F0F0F, 24);
        check("R10 ctrl2 unchanged", c2, 32'hC3F0A8);
        read_frame(23, 1'b0, g);
        check("R10 R9 flag survives foreign frame", g, word(1'b0));
        read_frame(23, 1'b0, g);
        check("R9 second read shows lock", g, word(1'b1));
    endtask

    task automatic t_read();
        logic [31:0] g;
        io1 = 1'b1; io2 = 1'b0; cval = 20'hA5C3E;
        read_frame(23, 1'b0, g);
        check("R6 read word pattern A", g, word(1'b1));
        io1 = 1'b0; io2 = 1'b1; cval = 20'h0F00D;
        read_frame(26, 1'b0, g);
        check("R6 read with extra clocks", g, {word(1'b1), 3'b000} & 32'h03FF_FFFF);
        read_frame(23, 1'b1, g);
        check("R7 capture at selection", g, word(1'b1));
        io1 = 1'b1; io2 = 1'b1;
    endtask

    task automatic t_sticky();
        logic [31:0] g;
        pulse_unlock();
        read_frame(23, 1'b0, g);
        check("R9 dummy read shows unlock", g, word(1'b0));
        read_frame(23, 1'b0, g);
        check("R9 next read shows lock", g, word(1'b1));
        pulse_unlock();
        write_frame(A_WR1, 32'hABCDEF, 24);
        read_frame(23, 1'b0, g);
        check("R9 write clears flag", g, word(1'b1));
    endtask

    task automatic t_mux();
        write_frame(A_WR2, 32'h000001, 24);
        wait_n(4);
        check("R8 sel001 flag clear", pull, 0);
        pulse_unlock();
        wait_n(2);
        check("R8 sel001 flag set", pull, 1);
        write_frame(A_WR2, 32'h000002, 24);
        cdone = 1'b1; wait_n(4);
        check("R8 sel010 done high", pull, 1);
        cdone = 1'b0; wait_n(4);
        check("R8 sel010 done low", pull, 0);
        write_frame(A_WR2, 32'h000006, 24);
        io2 = 1'b0; wait_n(4);
        check("R8 sel110 io2 low", pull, 1);
        io2 = 1'b1; wait_n(4);
        check("R8 sel110 io2 high", pull, 0);
        write_frame(A_WR2, 32'h000003, 24);
        pulse_unlock(); cdone = 1'b1; io1 = 1'b0; io2 = 1'b0; wait_n(4);
        check("R8 sel011 released", pull, 0);
        cdone = 1'b0; io2 = 1'b1;
        write_frame(A_WR2, 32'h000005, 24);
        wait_n(4);
        check("R8 sel101 io1 low", pull, 1);
    endtask

    task automatic t_write_release();
        open_frame(A_WR1);
        for (int i = 0; i < 12; i++) clk_bit(1'b1);
        check("R5 released during write", pull, 0);
        for (int i = 0; i < 12; i++) clk_bit(1'b0);
        check("R5 still released", pull, 0);
        close_frame();
        wait_n(4);
        check("R5 R3 ctrl1 after write", c1, 32'h000FFF);
        check("R8 status returns after write", pull, 1);
        io1 = 1'b1;
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_writes();
        t_bad_count();
        t_bad_addr();
        t_read();
        t_sticky();
        t_mux();
        t_write_release();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule